// File: doc/BRIEF.md
# Decoupled Load/Store Queue Unit

This unit connects the address side of a decoupled machine to its floating-point data side. The integer pipeline hands it store addresses and load requests, and each load request carries the floating-point destination tag its result is meant for. The floating-point pipeline supplies store data and takes load results, with their tags, from a queue. The address stream can therefore run several operations ahead of the data stream.

Store addresses and store data wait in two separate FIFOs. A store goes out to memory when both FIFOs hold an entry at their heads. The n-th data item always pairs with the n-th address. Every new load address is compared against all store addresses still pending. A load that matches one waits until that store has been written to memory. A load that matches none is sent to memory at once. Memory answers reads in request order, and each answer fills the next reserved slot of the load data queue.

The memory port is a valid/ready request channel plus a response strobe that has no backpressure. All three queues are `DEPTH` entries deep, and `DEPTH` must be a power of two.

Top module: `lsq_decouple`

## Requirements
- R1: After reset all queues are empty: `lw_valid` = 0, `sa_ready` = 1, `sd_ready` = 1, and `mem_req_valid` = 0 while no load is offered.
- R2: `sa_ready` is 1 exactly when fewer than `DEPTH` store addresses are pending, counting from the state at the start of the cycle.
- R3: `sd_ready` is 1 exactly when fewer than `DEPTH` store data items are pending.
- R4: A store request (`mem_req_we` = 1) is presented exactly when at least one address and one data item are pending. The address and data of the n-th store request are the n-th accepted address and the n-th accepted data item. No write request appears otherwise.
- R5: When a store can be presented, it takes the memory port, and `ld_ready` is 0 in that cycle.
- R6: A load whose address equals any pending store address, including a store still waiting for its data, is held with `ld_ready` = 0. The load is not forwarded data. A store address accepted in the same cycle as a load counts as younger than that load.
- R7: A load with no match, no store ready to go, fewer than `DEPTH` loads outstanding and `mem_req_ready` = 1 is accepted in the same cycle. In that cycle it appears as a read request (`mem_req_we` = 0) with `mem_req_addr` = `ld_addr`.
- R8: Load results leave in the order the loads were accepted, each paired with its own tag. Several outstanding loads may target the same tag. Each result equals the value written by the latest store accepted before its load, or the initial memory contents if there is none.
- R9: At most `DEPTH` loads are outstanding, counting both those in flight and those waiting in the data queue. While `DEPTH` are outstanding, `ld_ready` = 0.
- R10: `lw_valid` is 1 exactly when the oldest outstanding load has received its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa_valid | input | 1 | Store address offered |
| sa_ready | output | 1 | Store address queue has room |
| sa_addr | input | AW | Store address |
| sd_valid | input | 1 | Store data offered |
| sd_ready | output | 1 | Store data queue has room |
| sd_data | input | DW | Store data |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load accepted and sent to memory |
| ld_addr | input | AW | Load address |
| ld_tag | input | TW | Destination register tag of the load |
| lw_valid | output | 1 | Oldest load result available |
| lw_ready | input | 1 | Data side takes the result |
| lw_data | output | DW | Load result |
| lw_tag | output | TW | Destination tag of the result |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read response, in request order |
| mem_rsp_data | input | DW | Read response data |

## Verification
The hardest case to reach is a load that hits a store whose address is queued but whose data has not arrived yet. To hold up there, the unit must keep the load back for many cycles, and the correct value only becomes visible much later at the load data output. The stimulus draws addresses from only eight locations, and it lets the address side run well ahead of the data side, first in a directed phase and then at random rates. This makes such hits common. Every result is then compared with the program-order value of its location.

// File: rtl/lsq_decouple.sv
module lsq_decouple #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int TW    = 5,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sa_valid,
  output logic          sa_ready,
  input  logic [AW-1:0] sa_addr,
  input  logic          sd_valid,
  output logic          sd_ready,
  input  logic [DW-1:0] sd_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [TW-1:0] ld_tag,
  output logic          lw_valid,
  input  logic          lw_ready,
  output logic [DW-1:0] lw_data,
  output logic [TW-1:0] lw_tag,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);
  localparam logic [PW:0] ONE  = (PW+1)'(1);

  logic [AW-1:0] sa_mem [DEPTH];
  logic [DW-1:0] sd_mem [DEPTH];
  logic [DW-1:0] lq_data [DEPTH];
  logic [TW-1:0] lq_tag [DEPTH];

  logic [PW:0] sa_wp, sa_rp, sd_wp, sd_rp, lq_wp, lq_fp, lq_rp;
  logic [PW:0] sa_cnt, sd_cnt, lq_cnt;
  logic [DEPTH-1:0] hit_vec;
  logic hit, st_go, ld_fire, st_fire, sa_fire, sd_fire, lw_fire;

  assign sa_cnt = sa_wp - sa_rp;
  assign sd_cnt = sd_wp - sd_rp;
  assign lq_cnt = lq_wp - lq_rp;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [PW-1:0] off;
    assign off        = PW'(i) - sa_rp[PW-1:0];
    assign hit_vec[i] = ({1'b0, off} < sa_cnt) && (sa_mem[i] == ld_addr);
  end
  assign hit = |hit_vec;

  assign st_go    = (sa_cnt != '0) && (sd_cnt != '0);
  assign sa_ready = sa_cnt != FULL;
  assign sd_ready = sd_cnt != FULL;
  assign ld_ready = !hit && (lq_cnt != FULL) && !st_go && mem_req_ready;

  assign sa_fire = sa_valid && sa_ready;
  assign sd_fire = sd_valid && sd_ready;
  assign ld_fire = ld_valid && ld_ready;
  assign st_fire = st_go && mem_req_ready;
  assign lw_fire = lw_valid && lw_ready;

  assign mem_req_valid = st_go || (ld_valid && !hit && (lq_cnt != FULL));
  assign mem_req_we    = st_go;
  assign mem_req_addr  = st_go ? sa_mem[sa_rp[PW-1:0]] : ld_addr;
  assign mem_req_wdata = sd_mem[sd_rp[PW-1:0]];

  assign lw_valid = lq_fp != lq_rp;
  assign lw_data  = lq_data[lq_rp[PW-1:0]];
  assign lw_tag   = lq_tag[lq_rp[PW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_wp <= '0; sa_rp <= '0;
      sd_wp <= '0; sd_rp <= '0;
      lq_wp <= '0; lq_fp <= '0; lq_rp <= '0;
    end else begin
      if (sa_fire) sa_wp <= sa_wp + ONE;
      if (sd_fire) sd_wp <= sd_wp + ONE;
      if (st_fire) begin
        sa_rp <= sa_rp + ONE;
        sd_rp <= sd_rp + ONE;
      end
      if (ld_fire)       lq_wp <= lq_wp + ONE;
      if (mem_rsp_valid) lq_fp <= lq_fp + ONE;
      if (lw_fire)       lq_rp <= lq_rp + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (sa_fire)       sa_mem[sa_wp[PW-1:0]]  <= sa_addr;
    if (sd_fire)       sd_mem[sd_wp[PW-1:0]]  <= sd_data;
    if (ld_fire)       lq_tag[lq_wp[PW-1:0]]  <= ld_tag;
    if (mem_rsp_valid) lq_data[lq_fp[PW-1:0]] <= mem_rsp_data;
  end
endmodule

module lsq_decouple_chk #(
  parameter int AW    = 16,
  parameter int CW    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic [AW-1:0] ld_addr,
  input logic          mem_req_valid,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [CW-1:0] sa_cnt,
  input logic [CW-1:0] sd_cnt,
  input logic [CW-1:0] lq_cnt,
  input logic          lw_valid
);
  // R7
  load_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |-> (mem_req_valid && !mem_req_we && mem_req_addr == ld_addr));
  // R5
  store_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_cnt != '0 && sd_cnt != '0) |-> (mem_req_valid && mem_req_we && !ld_ready));
  // R9
  load_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_cnt == CW'(DEPTH)) |-> !ld_ready);
  // R2
  sa_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sa_cnt <= CW'(DEPTH));
  // R3
  sd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cnt <= CW'(DEPTH));
  // R10
  result_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lw_valid |-> lq_cnt != '0);
endmodule

bind lsq_decouple lsq_decouple_chk #(.AW(AW), .CW(PW+1), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
  .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .sa_cnt(sa_cnt), .sd_cnt(sd_cnt), .lq_cnt(lq_cnt), .lw_valid(lw_valid)
);

// File: tb/tb_lsq_decouple.sv
module tb_lsq_decouple;
  localparam int AW = 16, DW = 32, TW = 5, DEPTH = 8, NMAX = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sa_valid = 0, sa_ready, sd_valid = 0, sd_ready, ld_valid = 0, ld_ready;
  logic [AW-1:0] sa_addr = '0, ld_addr = '0, mem_req_addr;
  logic [DW-1:0] sd_data = '0, lw_data, mem_req_wdata, mem_rsp_data = '0;
  logic [TW-1:0] ld_tag = '0, lw_tag;
  logic lw_valid, lw_ready = 0, mem_req_valid, mem_req_ready = 0, mem_req_we, mem_rsp_valid = 0;

  lsq_decouple #(.AW(AW), .DW(DW), .TW(TW), .DEPTH(DEPTH)) dut (.*);

  always #5 clk = ~clk;

  int check_n = 0, pass_n = 0, cyc = 0;
  logic [AW-1:0] st_addr [NMAX];
  logic [DW-1:0] st_data [NMAX];
  int st_a_n = 0, st_d_n = 0, st_m_n = 0;
  int last_st [256];
  int lq_src [NMAX];
  logic [AW-1:0] lq_addr [NMAX];
  logic [TW-1:0] lq_tagq [NMAX];
  int lq_n = 0, lq_pop_n = 0;
  logic [DW-1:0] rsp_q [NMAX];
  int rsp_due [NMAX];
  int rsp_n = 0, rsp_del_n = 0, last_due = 0;
  logic [DW-1:0] mem_arr [256];
  int p_sa, p_sd, p_ld, p_lw, p_mr;

  function automatic logic [DW-1:0] init_val(logic [AW-1:0] a);
    return 32'hC0DE0000 ^ DW'(a);
  endfunction

  function automatic logic [DW-1:0] exp_load(int k);
    return (lq_src[k] < 0) ? init_val(lq_addr[k]) : st_data[lq_src[k]];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    check_n++;
    if (ok) pass_n++;
    else $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", pass_n, check_n);
    $finish;
  endtask

  task automatic step();
    bit stready, conflict, exp_ldr, exp_lw;
    bit f_sa, f_sd, f_ld, f_mem, f_lw, f_rsp;
    int outst;
    logic [AW-1:0] a_m;
    logic [DW-1:0] d_m;
    @(negedge clk);
    if (!sa_valid && st_a_n < NMAX - 1 && $urandom_range(99) < p_sa) begin
      st_addr[st_a_n] = AW'($urandom_range(7));
      sa_addr = st_addr[st_a_n]; sa_valid = 1;
    end
    if (!sd_valid && st_d_n < NMAX - 1 && $urandom_range(99) < p_sd) begin
      st_data[st_d_n] = $urandom;
      sd_data = st_data[st_d_n]; sd_valid = 1;
    end
    if (!ld_valid && lq_n < NMAX - 1 && $urandom_range(99) < p_ld) begin
      ld_addr = AW'($urandom_range(7)); ld_tag = TW'($urandom_range(3)); ld_valid = 1;
    end
    lw_ready      = $urandom_range(99) < p_lw;
    mem_req_ready = $urandom_range(99) < p_mr;
    if (rsp_del_n < rsp_n && rsp_due[rsp_del_n] <= cyc) begin
      mem_rsp_valid = 1; mem_rsp_data = rsp_q[rsp_del_n];
    end else mem_rsp_valid = 0;
    #2;
    stready  = (st_a_n > st_m_n) && (st_d_n > st_m_n);
    conflict = 0;
    for (int k = st_m_n; k < st_a_n; k++) if (st_addr[k] == ld_addr) conflict = 1;
    outst = lq_n - lq_pop_n;
    chk(sa_ready == (st_a_n - st_m_n < DEPTH), "R2", "sa_ready", sa_ready, st_a_n - st_m_n < DEPTH);
    chk(sd_ready == (st_d_n - st_m_n < DEPTH), "R3", "sd_ready", sd_ready, st_d_n - st_m_n < DEPTH);
    if (stready) begin
      chk(mem_req_valid && mem_req_we, "R4", "store request", {mem_req_valid, mem_req_we}, 3);
      chk(mem_req_addr == st_addr[st_m_n] && mem_req_wdata == st_data[st_m_n], "R4", "store pair",
          {mem_req_addr, mem_req_wdata}, {st_addr[st_m_n], st_data[st_m_n]});
    end else if (mem_req_valid)
      chk(!mem_req_we, "R4", "write without pair", mem_req_we, 0);
    if (ld_valid) begin
      exp_ldr = !stready && !conflict && outst < DEPTH && mem_req_ready;
      if (conflict)          chk(ld_ready == 0, "R6", "held load", ld_ready, 0);
      else if (stready)      chk(ld_ready == 0, "R5", "store priority", ld_ready, 0);
      else if (outst == DEPTH) chk(ld_ready == 0, "R9", "load limit", ld_ready, 0);
      else                   chk(ld_ready == exp_ldr, "R7", "ld_ready", ld_ready, exp_ldr);
      if (!stready && !conflict && outst < DEPTH)
        chk(mem_req_valid && !mem_req_we && mem_req_addr == ld_addr, "R7", "read request",
            {mem_req_valid, mem_req_we, mem_req_addr}, {2'b10, ld_addr});
    end else if (!stready)
      chk(!mem_req_valid, "R7", "idle request", mem_req_valid, 0);
    exp_lw = rsp_del_n > lq_pop_n;
    chk(lw_valid == exp_lw, "R10", "lw_valid", lw_valid, exp_lw);
    if (lw_valid && exp_lw) begin
      chk(lw_data == exp_load(lq_pop_n), "R8", "load data", lw_data, exp_load(lq_pop_n));
      chk(lw_tag == lq_tagq[lq_pop_n], "R8", "load tag", lw_tag, lq_tagq[lq_pop_n]);
    end
    f_sa = sa_valid && sa_ready;  f_sd = sd_valid && sd_ready;
    f_ld = ld_valid && ld_ready;  f_mem = mem_req_valid && mem_req_ready && mem_req_we;
    f_lw = lw_valid && lw_ready;  f_rsp = mem_rsp_valid;
    a_m = mem_req_addr; d_m = mem_req_wdata;
    @(posedge clk);
    #1;
    if (f_mem) begin mem_arr[a_m[7:0]] = d_m; st_m_n++; end
    if (f_ld) begin
      lq_src[lq_n] = last_st[ld_addr[7:0]];
      lq_addr[lq_n] = ld_addr; lq_tagq[lq_n] = ld_tag;
      rsp_q[rsp_n] = mem_arr[ld_addr[7:0]];
      last_due = (cyc + 1 + $urandom_range(3) > last_due) ? cyc + 1 + $urandom_range(3) : last_due;
      rsp_due[rsp_n] = last_due;
      rsp_n++; lq_n++; ld_valid = 0;
    end
    if (f_sa) begin last_st[sa_addr[7:0]] = st_a_n; st_a_n++; sa_valid = 0; end
    if (f_sd) begin st_d_n++; sd_valid = 0; end
    if (f_rsp) rsp_del_n++;
    if (f_lw) lq_pop_n++;
    cyc++;
  endtask

  task automatic run(input int n, input int a, input int d, input int l, input int w, input int m);
    p_sa = a; p_sd = d; p_ld = l; p_lw = w; p_mr = m;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) begin last_st[i] = -1; mem_arr[i] = init_val(AW'(i)); end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #2;
    chk(!lw_valid && !mem_req_valid, "R1", "reset outputs", {lw_valid, mem_req_valid}, 0);
    chk(sa_ready && sd_ready, "R1", "reset readies", {sa_ready, sd_ready}, 3);
    // R2 R6: address side runs ahead, loads wait on stores without data
    run(14, 100, 0, 60, 100, 100);
    // R3 R4: data catches up and stores drain in pairs
    run(30, 0, 100, 40, 100, 70);
    // R3: data arrives before any address
    run(12, 0, 100, 0, 100, 100);
    run(20, 100, 0, 0, 100, 100);
    // R9 R10: result side stalled, load queue fills
    run(30, 0, 0, 100, 0, 100);
    run(20, 0, 0, 50, 100, 100);
    // random mixes
    run(2000, 40, 40, 50, 60, 80);
    run(2000, 70, 30, 70, 30, 50);
    run(1500, 20, 60, 90, 90, 95);
    p_sa = 0; p_ld = 0; p_lw = 100; p_mr = 100;
    for (int i = 0; i < 600; i++) begin
      p_sd = (st_d_n < st_a_n) ? 100 : 0;
      if (lq_pop_n == lq_n && st_m_n == st_a_n && st_d_n <= st_a_n && !sa_valid && !ld_valid) break;
      step();
    end
    chk(lq_pop_n == lq_n, "R8", "all loads returned", lq_pop_n, lq_n);
    chk(st_m_n == st_a_n, "R4", "all stores drained", st_m_n, st_a_n);
    summary();
  end

  initial begin
    #1500000;
    check_n++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end
endmodule